// File: doc/BRIEF.md
# Full-Scan Test Sequencer

This block runs a complete full-scan test on an external scan chain that is wrapped around a small combinational circuit. The chain is built from multiplexed flip-flops. Each flip-flop takes the previous chain bit when scan mode is high and its functional input when scan mode is low. The sequencer drives three signals toward the chain: serial data in, scan mode, and the primary inputs of the circuit. It reads back the serial data out of the chain.

After a start pulse, the sequencer first shifts a fixed alternating pattern through the chain to exercise the flip-flops themselves. It then loads the first stimulus vector. For each vector, it drops scan mode for a single capture clock while the vector's primary-input word is applied. It then shifts the captured response out while the next vector shifts in. After the last response has been unloaded, done is raised and a latched fail flag reports whether any serial output bit differed from its expected value.

Stimulus, primary-input words and expected responses come from a vector store outside the block. The block addresses that store through an index output. Because unloading and loading overlap, the length of a run is fixed in closed form by the chain length and the vector count.

Top module: `scan_test_seq`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and after it is released, `busy`, `done`, `scanMode` and `testFail` are 0 until a start is accepted.
- R2: A run begins with CHAIN_LEN clocks with `scanMode`=1 that shift in the pattern 0,1,0,1,… (bit k of the sequence equals k mod 2). During the next CHAIN_LEN shifts, `scanOut` is compared with that same sequence, so a chain flip-flop stuck at 1 sets `testFail`.
- R3: Vectors are shifted MSB first. `stimVec[CHAIN_LEN-1]` enters first, so that at capture chain bit i equals `stimVec[i]`. The chain takes `scanIn` into bit 0 and presents bit CHAIN_LEN-1 on `scanOut`.
- R4: Each vector gets exactly one clock with `scanMode`=0 while busy. During that clock `primIn` equals the `stimPi` word of the addressed vector. A run contains exactly NUM_VEC such clocks.
- R5: After each capture, the response is shifted out MSB first and compared bit by bit with the `expResp` word that was presented at capture. The next vector is shifted in during the same clocks.
- R6: `busy` stays high for exactly 2·CHAIN_LEN + NUM_VEC·(CHAIN_LEN+1) clocks per run.
- R7: While the last response is unloaded, `scanIn` is 0, so the chain holds all zeros at the end. `done` is then held at 1 until the next start.
- R8: Any mismatch latches `testFail` to 1 for the rest of the run. An accepted start clears it. A run with no mismatch ends with `done`=1 and `testFail`=0.
- R9: A start pulse while `busy` is high is ignored, and the run length and result are unchanged.
- R10: `vecIdx` is 0 during the first load and advances by one at each capture except the last, so capture k addresses vector k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the scan chain |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| stimVec | input | CHAIN_LEN | Stimulus vector at index `vecIdx` |
| stimPi | input | PI_W | Primary-input word at index `vecIdx` |
| expResp | input | CHAIN_LEN | Expected captured response at index `vecIdx` |
| scanOut | input | 1 | Serial output of the chain's last flip-flop |
| vecIdx | output | VW | Vector store address |
| scanIn | output | 1 | Serial input to the chain's first flip-flop |
| scanMode | output | 1 | 1 = shift, 0 = functional capture |
| primIn | output | PI_W | Primary inputs applied to the circuit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; result valid |
| testFail | output | 1 | Latched mismatch flag |

## Verification
The bench models the chain and circuit. At every capture clock it checks that the chain holds the addressed vector exactly. A reversed bit order or an off-by-one in the shift count would leave a rotated vector there, and a missing index advance would repeat vector 0. Corrupting only the least significant bit of the last expected response targets the final unload: a sequencer that stops one shift early, or skips comparison in the final phase, would wrongly report a pass. A chain flip-flop held stuck at 1 targets the flush comparison. A second start issued mid-run, and a rerun after a failure, catch a restart that corrupts the run length or a fail flag that never clears.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_FLUSH = 2'd1,
    SRC_VEC   = 2'd2
  } scanSrc_e;

  typedef struct packed {
    logic     shiftEn;
    logic     captureEn;
    logic     clrFail;
    scanSrc_e srcSel;
    logic     cmpFlush;
    logic     cmpResp;
  } scanCtl_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int VW      = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          lastBit,
  output scanCtl_t      ctl,
  output logic [VW-1:0] vecIdx,
  output logic          scanMode,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FLUSH, ST_LOAD, ST_CAPTURE, ST_SHIFT, ST_DONE
  } seqState_e;

  localparam logic [VW-1:0] LAST_VEC = VW'(NUM_VEC - 1);

  seqState_e state;
  logic      finalShift;
  logic      accept;
  logic      lastVec;

  assign accept  = start && (state == ST_IDLE || state == ST_DONE);
  assign lastVec = (vecIdx == LAST_VEC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      vecIdx     <= '0;
      finalShift <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            state      <= ST_FLUSH;
            vecIdx     <= '0;
            finalShift <= 1'b0;
          end
        end
        ST_FLUSH:   if (lastBit) state <= ST_LOAD;
        ST_LOAD:    if (lastBit) state <= ST_CAPTURE;
        ST_CAPTURE: begin
          state <= ST_SHIFT;
          if (lastVec) finalShift <= 1'b1;
          else         vecIdx     <= vecIdx + 1'b1;
        end
        ST_SHIFT: begin
          if (lastBit) state <= finalShift ? ST_DONE : ST_CAPTURE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.srcSel    = SRC_ZERO;
    ctl.clrFail   = accept;
    unique case (state)
      ST_FLUSH: begin
        ctl.shiftEn = 1'b1;
        ctl.srcSel  = SRC_FLUSH;
      end
      ST_LOAD: begin
        ctl.shiftEn  = 1'b1;
        ctl.srcSel   = SRC_VEC;
        ctl.cmpFlush = 1'b1;
      end
      ST_CAPTURE: ctl.captureEn = 1'b1;
      ST_SHIFT: begin
        ctl.shiftEn = 1'b1;
        ctl.srcSel  = finalShift ? SRC_ZERO : SRC_VEC;
        ctl.cmpResp = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign done     = (state == ST_DONE);
  assign scanMode = ctl.shiftEn;

  // R4: a capture clock is always followed by a shift clock
  a_r4_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !scanMode) |=> (busy && scanMode));

  // R7: done holds until a new start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R1: no shifting while idle or done
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !scanMode);

  // R6: a run only ends in the done state
  a_r6_end_in_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int CW        = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanCtl_t             ctl,
  input  logic [CHAIN_LEN-1:0] stimVec,
  input  logic [CHAIN_LEN-1:0] expResp,
  input  logic                 scanOut,
  output logic                 scanIn,
  output logic                 lastBit,
  output logic                 testFail
);

  localparam logic [CW-1:0] LAST_BIT = CW'(CHAIN_LEN - 1);

  logic [CW-1:0]        bitCnt;
  logic [CW-1:0]        revIdx;
  logic [CHAIN_LEN-1:0] expReg;
  logic                 mismatch;

  assign lastBit = (bitCnt == LAST_BIT);
  assign revIdx  = LAST_BIT - bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         bitCnt <= '0;
    else if (ctl.clrFail)              bitCnt <= '0;
    else if (ctl.shiftEn)              bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    unique case (ctl.srcSel)
      SRC_FLUSH: scanIn = bitCnt[0];
      SRC_VEC:   scanIn = stimVec[revIdx];
      default:   scanIn = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              expReg <= '0;
    else if (ctl.captureEn) expReg <= expResp;
    else if (ctl.cmpResp)   expReg <= {expReg[CHAIN_LEN-2:0], 1'b0};
  end

  assign mismatch = (ctl.cmpFlush && (scanOut != bitCnt[0])) ||
                    (ctl.cmpResp  && (scanOut != expReg[CHAIN_LEN-1]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            testFail <= 1'b0;
    else if (ctl.clrFail) testFail <= 1'b0;
    else if (mismatch)    testFail <= 1'b1;
  end

  // R8: fail stays latched until a start clears it
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (testFail && !ctl.clrFail) |=> testFail);

  // R5: the bit counter only moves on shift clocks
  a_r5_count_on_shift: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shiftEn && !ctl.clrFail) |=> $stable(bitCnt));

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 4,
  parameter int PI_W      = 4,
  localparam int CW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int VW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] stimVec,
  input  logic [PI_W-1:0]      stimPi,
  input  logic [CHAIN_LEN-1:0] expResp,
  input  logic                 scanOut,
  output logic [VW-1:0]        vecIdx,
  output logic                 scanIn,
  output logic                 scanMode,
  output logic [PI_W-1:0]      primIn,
  output logic                 busy,
  output logic                 done,
  output logic                 testFail
);

  scanCtl_t ctl;
  logic     lastBit;

  scan_seq_ctrl #(.NUM_VEC(NUM_VEC), .VW(VW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lastBit(lastBit),
    .ctl(ctl), .vecIdx(vecIdx), .scanMode(scanMode),
    .busy(busy), .done(done)
  );

  scan_seq_dp #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stimVec(stimVec),
    .expResp(expResp), .scanOut(scanOut), .scanIn(scanIn),
    .lastBit(lastBit), .testFail(testFail)
  );

  assign primIn = busy ? stimPi : '0;

  // R8: an accepted start leaves the fail flag clear
  a_r8_fail_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !testFail);

endmodule

// File: tb/scan_test_seq_test.sv
module scan_test_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int V = 4;
  localparam int P = 4;
  localparam int RUN_LEN = 2 * N + V * (N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] stimVec, expResp;
  logic [P-1:0] stimPi, primIn;
  logic scanOut, scanIn, scanMode, busy, done, testFail;
  logic [1:0] vecIdx;

  logic [N-1:0] vecs [V];
  logic [P-1:0] pis  [V];
  logic [N-1:0] chain;
  logic [N-1:0] stuckMask = '0;
  logic [N-1:0] corruptMask = '0;
  int corruptIdx = 0;
  bit monitorOn = 1'b0;
  int capCnt = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [N-1:0] circuit(logic [N-1:0] s, logic [P-1:0] p);
    return {s[3:0] ^ p, s[7:4] + s[3:0]};
  endfunction

  assign stimVec = vecs[vecIdx];
  assign stimPi  = pis[vecIdx];
  assign expResp = circuit(vecs[vecIdx], pis[vecIdx]) ^
                   ((int'(vecIdx) == corruptIdx) ? corruptMask : '0);
  assign scanOut = chain[N-1];

  always_ff @(posedge clk) begin
    if (scanMode) chain <= {chain[N-2:0], scanIn} | stuckMask;
    else          chain <= circuit(chain, primIn) | stuckMask;
  end

  scan_test_seq #(.CHAIN_LEN(N), .NUM_VEC(V), .PI_W(P)) uut (
    .clk(clk), .rstN(rstN), .start(start), .stimVec(stimVec),
    .stimPi(stimPi), .expResp(expResp), .scanOut(scanOut),
    .vecIdx(vecIdx), .scanIn(scanIn), .scanMode(scanMode),
    .primIn(primIn), .busy(busy), .done(done), .testFail(testFail)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // capture-clock monitor: R3 chain contents, R4 primary inputs, R10 index
  always @(negedge clk) begin
    if (busy && !scanMode) begin
      if (monitorOn) begin
        check("R3 chain at capture", chain, vecs[capCnt % V]);
        check("R4 primIn at capture", primIn, pis[capCnt % V]);
        check("R10 vecIdx at capture", vecIdx, capCnt % V);
      end
      capCnt++;
    end
  end

  task automatic runTest(string name, bit expFail, bit midStart);
    int cyc = 0;
    int guard = 0;
    capCnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && guard < 2000) begin
      if (busy) cyc++;
      if (midStart && cyc == 10) start = 1'b1;
      else start = 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    check({"R6 run length ", name}, cyc, RUN_LEN);
    check({"R4 capture count ", name}, capCnt, V);
    check({"R7 done ", name}, done, 1'b1);
    check({"R8 result ", name}, testFail, expFail);
    if (stuckMask == '0) check({"R7 chain zero ", name}, chain, '0);
    repeat (3) @(negedge clk);
    check({"R7 done held ", name}, done, 1'b1);
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    check("R1 busy in reset", busy, 1'b0);
    check("R1 scanMode in reset", scanMode, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", done, 1'b0);
    check("R1 fail after reset", testFail, 1'b0);
    check("R1 busy after reset", busy, 1'b0);
  endtask

  task automatic testGoodRun();
    vecs = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    pis  = '{4'h3, 4'hF, 4'h0, 4'h9};
    monitorOn = 1'b1;
    runTest("good set A", 1'b0, 1'b0);
  endtask

  task automatic testSecondSet();
    vecs = '{8'h80, 8'h7E, 8'h00, 8'hC3};
    pis  = '{4'hA, 4'h5, 4'h1, 4'hE};
    runTest("good set B", 1'b0, 1'b0);
  endtask

  task automatic testBadExpect();
    corruptIdx  = V - 1;
    corruptMask = 8'h01;   // R5: only the last bit of the last response
    runTest("R5 corrupt last bit", 1'b1, 1'b0);
    corruptMask = '0;
  endtask

  task automatic testRerunClears();
    runTest("R8 rerun after fail", 1'b0, 1'b0);
  endtask

  task automatic testStuckChain();
    monitorOn = 1'b0;
    stuckMask = 8'h08;     // R2: flip-flop 3 stuck at 1
    runTest("R2 stuck flop", 1'b1, 1'b0);
    stuckMask = '0;
    monitorOn = 1'b1;
  endtask

  task automatic testStartWhileBusy();
    runTest("R9 start while busy", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    chain = '0;
    vecs = '{default: '0};
    pis  = '{default: '0};
    testReset();
    testGoodRun();
    testSecondSet();
    testBadExpect();
    testRerunClears();
    testStuckChain();
    testRerunClears();
    testStartWhileBusy();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule